// File: doc/BRIEF.md
# UDP/IPv4 Header Prepender with Checksum Completion

This block sits in an outgoing packet path and puts a complete Ethernet, IPv4 and UDP header in front of every payload stream that passes through it. The payload arrives as 16-bit words on a valid/ready interface. The byte count of the payload is presented on a length input together with the first payload word. The block holds that first word, sends 21 header halfwords in network byte order, and then passes the payload through unchanged.

Software programs the fields that stay the same from packet to packet: both MAC addresses, both IPv4 addresses and both UDP ports. It also programs a partial IPv4 header checksum. This is the one's-complement sum of every static IP header halfword, leaving out the total-length halfword. For each packet the hardware derives the IP total length and the UDP length from the sampled payload byte count. It adds the total length into the partial sum, folds the carry back in, and inverts the result to produce the header checksum. The UDP checksum is always sent as zero.

Top module: `udp_prep`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `tx_valid` and `pay_ready` are both low.
- R2: A packet begins with 21 header halfwords, sent before any payload word. Halfwords 0 to 2 carry the destination MAC and halfwords 3 to 5 the source MAC. The first octet of each MAC is in the upper byte of halfword 0 (or halfword 3). Halfword 6 is the ethertype 0x0800.
- R3: Halfwords 7, 9, 10 and 11 are the fixed IP words 0x4500, 0x0000, 0x4000 and 0x2011.
- R4: Halfword 8 is the IP total length, equal to the sampled payload byte count plus 28.
- R5: Halfword 12 is the IP checksum. It equals the bitwise inverse of `sw_csum_part` plus the total length, with any carry out of bit 15 added back in.
- R6: Halfwords 13 and 14 are the source IP address, upper half first. Halfwords 15 and 16 are the destination IP address. Halfword 17 is the source UDP port and halfword 18 the destination UDP port.
- R7: Halfword 19 is the UDP length, equal to the payload byte count plus 8. Halfword 20 is zero and is the last header halfword.
- R8: No payload word is accepted (`pay_ready` stays low) until all 21 header halfwords have been accepted downstream. After that, each payload word leaves unchanged and in order, and `tx_last` is set only on the final payload word.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values and `tx_valid` stays high.
- R10: `pay_len` is sampled only when a packet starts, that is, when `pay_valid` is seen with the block idle. Changes to `pay_len` later in the packet have no effect on the length or checksum halfwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_dst_mac | input | 48 | Destination MAC, first octet in bits 47:40 |
| sw_src_mac | input | 48 | Source MAC, first octet in bits 47:40 |
| sw_src_ip | input | 32 | Source IPv4 address |
| sw_dst_ip | input | 32 | Destination IPv4 address |
| sw_src_port | input | 16 | Source UDP port |
| sw_dst_port | input | 16 | Destination UDP port |
| sw_csum_part | input | 16 | Partial one's-complement sum over the static IP halfwords |
| pay_valid | input | 1 | Payload word valid |
| pay_ready | output | 1 | Payload word accepted |
| pay_data | input | 16 | Payload word |
| pay_last | input | 1 | Final payload word of the packet |
| pay_len | input | 16 | Payload byte count, sampled at packet start |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Downstream accepts the output word |
| tx_data | output | 16 | Output word (header, then payload) |
| tx_last | output | 1 | Final word of the outgoing packet |

## Verification
The bench drives checksum cases where the partial sum plus the total length carries out of bit 15, and a case where that sum is exactly 0xFFFF so the inverted checksum is zero. A design that dropped the end-around carry, or inverted before folding, would send a checksum that is off by one or that has the wrong polarity. It also changes `pay_len` after a packet has started and applies backpressure that stalls the stream in both the header and the payload phases. A design that sampled the length continuously would corrupt the length and checksum halfwords. A design that advanced on a stalled beat would skip or repeat a header halfword or a payload word.

// File: rtl/udp_prep_pkg.sv
// Shared constants, configuration type and one's-complement helper for the
// UDP/IPv4 header prepender. Assumes 16-bit header and payload words.
package udp_prep_pkg;
    localparam int WORD_W        = 16;
    localparam int LEN_W         = 16;
    localparam int ETH_HWORDS    = 7;
    localparam int IP_HWORDS     = 10;
    localparam int UDP_HWORDS    = 4;
    localparam int HDR_WORDS     = ETH_HWORDS + IP_HWORDS + UDP_HWORDS;
    localparam int IDX_W         = $clog2(HDR_WORDS);
    localparam int UDP_HDR_BYTES = 2 * UDP_HWORDS;
    localparam int IP_ADD_BYTES  = 2 * IP_HWORDS + UDP_HDR_BYTES;

    localparam logic [WORD_W-1:0] ETYPE_IPV4   = 16'h0800;
    localparam logic [WORD_W-1:0] IP_VER_TOS   = 16'h4500;
    localparam logic [WORD_W-1:0] IP_IDENT     = 16'h0000;
    localparam logic [WORD_W-1:0] IP_FLAGS_DF  = 16'h4000;
    localparam logic [WORD_W-1:0] IP_TTL_PROTO = 16'h2011;

    typedef struct packed {
        logic [47:0] dst_mac;
        logic [47:0] src_mac;
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
        logic [15:0] src_port;
        logic [15:0] dst_port;
    } hdr_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} prep_state_t;

    // One's-complement add of two halfwords with the carry folded back twice.
    function automatic logic [WORD_W-1:0] oc_add(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        s = {1'b0, s[WORD_W-1:0]} + {{WORD_W{1'b0}}, s[WORD_W]};
        s = {1'b0, s[WORD_W-1:0]} + {{WORD_W{1'b0}}, s[WORD_W]};
        return s[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/udp_prep_len.sv
// Per-packet length and checksum finisher. Registers the IP total length,
// the UDP length and the completed IP checksum when load is pulsed.
// Assumes the payload byte count plus the header bytes fits in LEN_W bits.
module udp_prep_len
    import udp_prep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  pay_bytes,
    input  logic [WORD_W-1:0] csum_part,
    output logic [WORD_W-1:0] ip_len,
    output logic [WORD_W-1:0] udp_len,
    output logic [WORD_W-1:0] ip_csum
);
    logic [WORD_W-1:0] ip_len_nxt;

    // Total length follows directly from the sampled payload byte count.
    always_comb ip_len_nxt = WORD_W'(pay_bytes) + WORD_W'(IP_ADD_BYTES);

    // Capture lengths and finish the checksum at packet start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_len  <= '0;
            udp_len <= '0;
            ip_csum <= '0;
        end else if (load) begin
            ip_len  <= ip_len_nxt;
            udp_len <= WORD_W'(pay_bytes) + WORD_W'(UDP_HDR_BYTES);
            ip_csum <= ~oc_add(csum_part, ip_len_nxt);
        end
    end
endmodule

// File: rtl/udp_prep_hdr.sv
// Header word selector: returns header halfword idx in network byte order
// from the static configuration and the per-packet length/checksum words.
// Purely combinational; idx values beyond the header return zero.
module udp_prep_hdr
    import udp_prep_pkg::*;
(
    input  hdr_cfg_t          cfg,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] ip_len,
    input  logic [WORD_W-1:0] udp_len,
    input  logic [WORD_W-1:0] ip_csum,
    output logic [WORD_W-1:0] word
);
    // Select the halfword for the current header position.
    always_comb begin
        case (idx)
            5'd0:    word = cfg.dst_mac[47:32];
            5'd1:    word = cfg.dst_mac[31:16];
            5'd2:    word = cfg.dst_mac[15:0];
            5'd3:    word = cfg.src_mac[47:32];
            5'd4:    word = cfg.src_mac[31:16];
            5'd5:    word = cfg.src_mac[15:0];
            5'd6:    word = ETYPE_IPV4;
            5'd7:    word = IP_VER_TOS;
            5'd8:    word = ip_len;
            5'd9:    word = IP_IDENT;
            5'd10:   word = IP_FLAGS_DF;
            5'd11:   word = IP_TTL_PROTO;
            5'd12:   word = ip_csum;
            5'd13:   word = cfg.src_ip[31:16];
            5'd14:   word = cfg.src_ip[15:0];
            5'd15:   word = cfg.dst_ip[31:16];
            5'd16:   word = cfg.dst_ip[15:0];
            5'd17:   word = cfg.src_port;
            5'd18:   word = cfg.dst_port;
            5'd19:   word = udp_len;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/udp_prep.sv
// UDP/IPv4 header prepender. On seeing the first payload word while idle
// it samples pay_len, sends HDR_WORDS header halfwords, then forwards the
// payload with valid/ready passthrough. Assumes the configuration inputs
// stay stable during a packet and every packet has at least one word.
module udp_prep
    import udp_prep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       sw_dst_mac,
    input  logic [47:0]       sw_src_mac,
    input  logic [31:0]       sw_src_ip,
    input  logic [31:0]       sw_dst_ip,
    input  logic [15:0]       sw_src_port,
    input  logic [15:0]       sw_dst_port,
    input  logic [15:0]       sw_csum_part,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [15:0]       pay_data,
    input  logic              pay_last,
    input  logic [15:0]       pay_len,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [15:0]       tx_data,
    output logic              tx_last
);
    prep_state_t       st;
    logic [IDX_W-1:0]  idx;
    logic              start;
    hdr_cfg_t          cfg;
    logic [WORD_W-1:0] ip_len, udp_len, ip_csum, hdr_word;

    // Gather static fields into one record.
    always_comb cfg = '{dst_mac: sw_dst_mac, src_mac: sw_src_mac,
                        src_ip: sw_src_ip, dst_ip: sw_dst_ip,
                        src_port: sw_src_port, dst_port: sw_dst_port};

    // A packet starts when payload appears while idle.
    always_comb start = (st == ST_IDLE) && pay_valid;

    udp_prep_len u_len (
        .clk(clk), .rst_n(rst_n), .load(start), .pay_bytes(pay_len),
        .csum_part(sw_csum_part), .ip_len(ip_len), .udp_len(udp_len),
        .ip_csum(ip_csum)
    );

    udp_prep_hdr u_hdr (
        .cfg(cfg), .idx(idx), .ip_len(ip_len), .udp_len(udp_len),
        .ip_csum(ip_csum), .word(hdr_word)
    );

    // Sequence idle -> header -> payload -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_HDR;
                    idx <= '0;
                end
                ST_HDR: if (tx_ready) begin
                    if (idx == IDX_W'(HDR_WORDS - 1)) st <= ST_PAY;
                    else                              idx <= idx + 1'b1;
                end
                ST_PAY: if (pay_valid && tx_ready && pay_last) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the output stream from the header selector or the payload.
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = hdr_word;
        tx_last   = 1'b0;
        pay_ready = 1'b0;
        case (st)
            ST_HDR: tx_valid = 1'b1;
            ST_PAY: begin
                tx_valid  = pay_valid;
                tx_data   = pay_data;
                tx_last   = pay_last;
                pay_ready = tx_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/udp_prep_chk.sv
// Protocol checker for udp_prep: counts accepted output beats per packet
// and checks header ordering and handshake rules at the ports.
module udp_prep_chk
    import udp_prep_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        pay_ready,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [15:0] tx_data,
    input logic        tx_last
);
    logic [IDX_W:0] beats;

    // Count accepted beats since packet start, saturating after the header.
    always_ff @(posedge clk) begin
        if (!rst_n) beats <= '0;
        else if (tx_valid && tx_ready) begin
            if (tx_last)                            beats <= '0;
            else if (beats < (IDX_W+1)'(HDR_WORDS)) beats <= beats + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!tx_valid && !pay_ready));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_no_early_pay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beats < (IDX_W+1)'(HDR_WORDS)) |-> !pay_ready);

    assert_ready_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> tx_ready);

    assert_ethertype_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && beats == (IDX_W+1)'(6)) |-> tx_data == ETYPE_IPV4);

    assert_udp_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && beats == (IDX_W+1)'(HDR_WORDS - 1)) |-> (tx_data == 16'h0000 && !tx_last));
endmodule

bind udp_prep udp_prep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pay_ready(pay_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
);

// File: tb/udp_prep_tb.sv
module udp_prep_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] sw_dst_mac = 48'h0A1B2C3D4E5F;
    logic [47:0] sw_src_mac = 48'hF0E1D2C3B4A5;
    logic [31:0] sw_src_ip  = 32'hC0A80A02;
    logic [31:0] sw_dst_ip  = 32'hC0A80A99;
    logic [15:0] sw_src_port = 16'd49152;
    logic [15:0] sw_dst_port = 16'd50000;
    logic [15:0] sw_csum_part = '0;
    logic        pay_valid = 1'b0, pay_last = 1'b0, tx_ready = 1'b0;
    logic [15:0] pay_data = '0, pay_len = '0;
    logic        pay_ready, tx_valid, tx_last;
    logic [15:0] tx_data;
    int vectors = 0, miscompares = 0;

    always #5 clk = ~clk;

    udp_prep u_dut (.*);

    function automatic logic [15:0] fold_add(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] t;
        t = 32'(a) + 32'(b);
        t = (t & 32'hFFFF) + (t >> 16);
        t = (t & 32'hFFFF) + (t >> 16);
        return t[15:0];
    endfunction

    // Partial sum as software would compute it (static words, no length).
    function automatic logic [15:0] sw_partial();
        logic [15:0] s;
        s = 16'h0;
        s = fold_add(s, 16'h4500); s = fold_add(s, 16'h0000);
        s = fold_add(s, 16'h4000); s = fold_add(s, 16'h2011);
        s = fold_add(s, sw_src_ip[31:16]); s = fold_add(s, sw_src_ip[15:0]);
        s = fold_add(s, sw_dst_ip[31:16]); s = fold_add(s, sw_dst_ip[15:0]);
        return s;
    endfunction

    function automatic logic [15:0] exp_hdr(input int i, input logic [15:0] len,
                                            input logic [15:0] part);
        logic [15:0] tl;
        tl = len + 16'd28;
        case (i)
            0: return sw_dst_mac[47:32];  1: return sw_dst_mac[31:16];
            2: return sw_dst_mac[15:0];   3: return sw_src_mac[47:32];
            4: return sw_src_mac[31:16];  5: return sw_src_mac[15:0];
            6: return 16'h0800;           7: return 16'h4500;
            8: return tl;                 9: return 16'h0000;
            10: return 16'h4000;          11: return 16'h2011;
            12: return ~fold_add(part, tl);
            13: return sw_src_ip[31:16];  14: return sw_src_ip[15:0];
            15: return sw_dst_ip[31:16];  16: return sw_dst_ip[15:0];
            17: return sw_src_port;       18: return sw_dst_port;
            19: return len + 16'd8;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of(input int i);
        if (i <= 6) return "R2";
        if (i == 8) return "R4";
        if (i == 12) return "R5";
        if (i <= 11) return "R3";
        if (i <= 18) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Send one packet of n payload words and check every output beat.
    // stall: tx_ready low every stall-th cycle (0 = never); gap likewise for
    // pay_valid; junk_len: change pay_len after start (R10).
    task automatic run_pkt(input int n, input logic [15:0] len, input logic [15:0] part,
                           input int stall, input int gap, input bit junk_len, input int tag);
        int sent = 0, rcv = 0, cyc = 0;
        bit acc = 0;
        sw_csum_part = part;
        pay_len = len;
        while (rcv < n + 21 && cyc < 3000) begin
            @(negedge clk);
            if (acc) begin pay_valid = 1'b0; acc = 0; end
            tx_ready = (stall == 0) || (cyc % stall != 0);
            if (!pay_valid && sent < n) pay_valid = (gap == 0) || (cyc % gap != 0);
            pay_data = {tag[7:0], sent[7:0]};
            pay_last = (sent == n - 1);
            if (junk_len && rcv > 0) pay_len = 16'hBEEF;
            #1;
            if (tx_valid && tx_ready) begin
                if (rcv < 21) begin
                    check(tx_data == exp_hdr(rcv, len, part), req_of(rcv),
                          $sformatf("header halfword %0d", rcv), 32'(tx_data),
                          32'(exp_hdr(rcv, len, part)));
                    check(!tx_last, "R8", "tx_last during header", 32'(tx_last), 0);
                end else begin
                    check(tx_data == {tag[7:0], 8'(rcv - 21)}, "R8", "payload word",
                          32'(tx_data), 32'({tag[7:0], 8'(rcv - 21)}));
                    check(tx_last == (rcv == n + 20), "R8", "tx_last position",
                          32'(tx_last), 32'(rcv == n + 20));
                end
                rcv++;
            end
            if (pay_valid && pay_ready) begin
                check(rcv > 21, "R8", "payload taken before header done", rcv, 22);
                sent++;
                acc = 1;
            end
            cyc++;
        end
        check(rcv == n + 21, "R8", "beats received", rcv, n + 21);
        @(negedge clk);
        if (acc) pay_valid = 1'b0;
        pay_last = 1'b0;
        tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!tx_valid && !pay_ready, "R1", "outputs during reset", {tx_valid, pay_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && !pay_ready, "R1", "outputs after reset", {tx_valid, pay_ready}, 0);
    endtask

    // R2..R8: plain packet, no stalls, software-style partial sum.
    task automatic t_basic();
        run_pkt(4, 16'd8, sw_partial(), 0, 0, 0, 1);
    endtask

    // R9, R10: downstream stalls, upstream gaps, pay_len changed mid-packet.
    task automatic t_stall();
        run_pkt(7, 16'd13, sw_partial(), 3, 4, 1, 2);
    endtask

    // R5: partial sum + total length carries out of bit 15 (0xFFF0+0x20 -> ~0x0011).
    task automatic t_carry();
        run_pkt(2, 16'd4, 16'hFFF0, 0, 0, 0, 3);
        check(exp_hdr(12, 16'd4, 16'hFFF0) == 16'hFFEE, "R5", "bench carry model",
              32'(exp_hdr(12, 16'd4, 16'hFFF0)), 32'hFFEE);
    endtask

    // R5: sum exactly 0xFFFF gives checksum 0x0000; single-word packet.
    task automatic t_zero_ck();
        run_pkt(1, 16'd2, 16'hFFFF - 16'd30, 2, 0, 0, 4);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_stall();
        t_carry();
        t_zero_ck();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule